// File: doc/BRIEF.md
# Prime-Modulo Bank Address Mapper

This block splits a linear word address into a bank number and a word position inside that bank, for a memory built from a prime number of banks. The bank count is 2^K − 1, so 3 or 7 banks, for example. Strided walks that would pile onto one bank under plain low-bit interleaving are spread out instead. Matrix rows and matrix columns are the main case.

The bank number is the address reduced modulo 2^K − 1, and no divider is used. The address is cut into K-bit digits and the digits are added. The sum is cut and added again until it fits in K bits. A final result of 2^K − 1 counts as zero. The word inside the bank is the address modulo the words per bank. That count is a power of two, so it is just the low OFFW address bits.

One registered stage with a valid/ready handshake sits on each side of the mapping. It returns the original address next to the two computed fields.

Top module: `prime_bank_map`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0.
- R2: For every delivered result, `out_bank` equals `out_addr` modulo 2^K − 1 (3 with the default K=2), and it is always below 2^K − 1.
- R3: For every delivered result, `out_offset` equals `out_addr` modulo 2^OFFW, which is the low OFFW bits (16 words with the default OFFW=4).
- R4: An address whose digit sum folds to exactly 2^K − 1 maps to bank 0. Examples are 3, 0x000F and 0xFFFF with K=2.
- R5: An address accepted on a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high after that edge. If nothing is accepted while the output is taken, `out_valid` falls.
- R6: While `out_valid` is high and `out_ready` is low, the outputs hold their values and `in_ready` is low.
- R7: While `out_ready` is high, `in_ready` is high, so a new address is accepted every cycle.
- R8: With 3 banks, walking a row-major 4x4 matrix along any row or down any column gives consecutive addresses in different banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input address is valid |
| in_ready | output | 1 | Stage can accept an address |
| in_addr | input | AW | Linear word address |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | AW | Address the result belongs to |
| out_bank | output | K | Bank number, 0 to 2^K − 2 |
| out_offset | output | OFFW | Word position inside the bank |

## Verification
The handshake checks expect the consumer to keep `out_ready` at a defined level and to lower it only while it wants to hold a result. The bench drives `out_ready` high for the streaming and random phases and drops it only in the stall test.

The bank and offset checks hold for any address. For that reason the stimulus draws addresses from the whole 16-bit range. It adds directed values whose digit sums land on 2^K − 1, plus the all-zero and all-one patterns.

// File: rtl/prime_bank_map.sv
module prime_bank_map #(
  parameter int AW   = 16,
  parameter int K    = 2,
  parameter int OFFW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [AW-1:0]   in_addr,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [AW-1:0]   out_addr,
  output logic [K-1:0]    out_bank,
  output logic [OFFW-1:0] out_offset
);
  localparam int NBANK = (1 << K) - 1;
  localparam int NDIG  = (AW + K - 1) / K;

  function automatic logic [K-1:0] fold_mod(input logic [AW-1:0] a);
    logic [31:0] s;
    logic [31:0] t;
    s = 32'(a);
    for (int it = 0; it < AW; it++) begin
      t = '0;
      for (int d = 0; d < NDIG; d++)
        t = t + ((s >> (d * K)) & 32'(NBANK));
      s = t;
    end
    if (s == 32'(NBANK)) s = '0;
    return s[K-1:0];
  endfunction

  logic [K-1:0] bank_d;
  assign bank_d   = fold_mod(in_addr);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_bank   <= '0;
      out_offset <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr   <= in_addr;
        out_bank   <= bank_d;
        out_offset <= in_addr[OFFW-1:0];
      end
    end
  end
endmodule

// File: rtl/prime_bank_map_chk.sv
module prime_bank_map_chk #(
  parameter int AW   = 16,
  parameter int K    = 2,
  parameter int OFFW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [AW-1:0]   in_addr,
  input logic            out_valid,
  input logic            out_ready,
  input logic [AW-1:0]   out_addr,
  input logic [K-1:0]    out_bank,
  input logic [OFFW-1:0] out_offset
);
  localparam int NBANK = (1 << K) - 1;

  AST_BANK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_bank) == (32'(out_addr) % NBANK))); // R2
  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_bank) < NBANK)); // R2
  AST_OFFSET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_offset) == (32'(out_addr) % (1 << OFFW)))); // R3
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R5
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && out_ready) |=> !out_valid); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_bank) && $stable(out_offset))); // R6
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R6
  AST_READY_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready); // R7
endmodule

bind prime_bank_map prime_bank_map_chk #(.AW(AW), .K(K), .OFFW(OFFW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_bank(out_bank), .out_offset(out_offset)
);

// File: tb/prime_bank_map_tb_top.sv
module prime_bank_map_tb_top;
  localparam int AW = 16, K = 2, OFFW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [AW-1:0] in_addr = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [AW-1:0] out_addr;
  logic [K-1:0] out_bank;
  logic [OFFW-1:0] out_offset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prime_bank_map #(.AW(AW), .K(K), .OFFW(OFFW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_bank(out_bank), .out_offset(out_offset)
  );

  function automatic int exp_bank(input logic [AW-1:0] a);
    return int'(a) % 3;
  endfunction

  function automatic int exp_off(input logic [AW-1:0] a);
    return int'(a) % 16;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic map_one(input logic [AW-1:0] a, input string req, output int bank);
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " addr"}, int'(out_addr), int'(a));
    chk({req, " bank"}, int'(out_bank), exp_bank(a));
    chk({req, " offset"}, int'(out_offset), exp_off(a));
    bank = int'(out_bank);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int b;
    int prev;
    void'($urandom(32'd20161117));
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset valid", int'(out_valid), 0);

    // R4 and R2: fold boundary values
    map_one(16'd0, "R2 zero", b);
    map_one(16'd3, "R4 three", b);
    map_one(16'h000F, "R4 0x000F", b);
    map_one(16'hFFFF, "R4 0xFFFF", b);
    map_one(16'hFFFE, "R2 0xFFFE", b);
    map_one(16'h5555, "R2 0x5555", b);
    map_one(16'hAAAA, "R3 0xAAAA", b);
    @(negedge clk);
    chk("R5 drained", int'(out_valid), 0);

    // R8: rows and columns of a 4x4 row-major matrix
    for (int r = 0; r < 4; r++) begin
      prev = -1;
      for (int c = 0; c < 4; c++) begin
        map_one(AW'(4 * r + c), "R8 row", b);
        if (prev >= 0) chk("R8 row differs", int'(b != prev), 1);
        prev = b;
      end
    end
    for (int c = 0; c < 4; c++) begin
      prev = -1;
      for (int r = 0; r < 4; r++) begin
        map_one(AW'(4 * r + c), "R8 col", b);
        if (prev >= 0) chk("R8 col differs", int'(b != prev), 1);
        prev = b;
      end
    end

    // R7 and R5: back-to-back stream
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      in_valid = 1'b1;
      in_addr  = a;
      chk("R7 ready while draining", int'(in_ready), 1);
      @(negedge clk);
      chk("R5 stream valid", int'(out_valid), 1);
      chk("R2 stream bank", int'(out_bank), exp_bank(a));
      chk("R3 stream offset", int'(out_offset), exp_off(a));
    end
    in_valid = 1'b0;
    @(negedge clk);

    // R6: stall holds the result
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_addr   = 16'd1234;
    @(negedge clk);
    in_addr = 16'd777;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R6 stall ready low", int'(in_ready), 0);
      chk("R6 stall addr", int'(out_addr), 1234);
      chk("R6 stall bank", int'(out_bank), exp_bank(16'd1234));
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 next addr", int'(out_addr), 777);
    chk("R6 next bank", int'(out_bank), exp_bank(16'd777));
    @(negedge clk);

    // random single transfers
    for (int i = 0; i < 300; i++) map_one(AW'($urandom), "R2 random", b);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule